// File: doc/BRIEF.md
# Local/Remote Memory Request Router

This block sits on the path of coherent main-memory requests inside a node. Each accepted request is classified as local or remote by comparing its address with a small bank of programmable local range entries. Every request gives rise to a request on one of two scalability ports, because all main-memory traffic is coherent. A local hit produces a snoop-only port request and hands the data access to the local memory controller. A miss produces a read or a write towards the home node.

The port is picked by interleaving one address bit above the cache-line offset around a programmable default port. A configuration input marks a single-node system, in which every request is local. Software must keep the default port equal to the setting used by the I/O hub in that case. Range entries and the global settings are written through a simple register write port. The result is registered and appears one cycle after the request.

Top module: `mem_req_router`

## Requirements
- R1: A request presented with `req_valid` high produces `rsp_valid` high exactly one clock later. A cycle without a request gives all response outputs at zero on the next cycle.
- R2: A range entry matches when it is enabled and `base <= req_addr <= limit`, both bounds inclusive. A match makes the response local, with `rsp_node` taken from that entry's node field.
- R3: When several enabled entries match, the entry with the lowest index decides the node.
- R4: A request that matches no entry is remote, and `rsp_node` is the default home node.
- R5: A local response has `rsp_kind` = 0 (snoop only) and `mc_valid` = 1, and `mc_write` equals the request's write flag.
- R6: A remote response has `rsp_kind` = 1 for a read or 2 for a write, and `mc_valid` = 0 and `mc_write` = 0.
- R7: `rsp_port` equals `req_addr[LINE_BITS]` (bit 6 by default) XOR the default port setting.
- R8: While `single_node` is high, every request is local with `rsp_kind` = 0. The node still follows R2 to R4.
- R9: A write with `cfg_we` high updates the register picked by `cfg_field`. Field 0 writes the entry base from `cfg_wdata`, and field 1 writes the entry limit. Field 2 writes the entry control word: enable in bit 0 and node in bits NODE_W:1. Field 3 writes the global word: default port in bit 0 and default home node in bits NODE_W:1, and `cfg_idx` is ignored. A request in the same cycle as a write is routed with the settings held before that write.
- R10: After reset, every entry is disabled with zero base, limit and node, and the default port and default home node are 0.
- R11: A disabled entry never matches, even when the address lies inside its bounds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| single_node | input | 1 | System has a single node |
| cfg_we | input | 1 | Register write strobe |
| cfg_field | input | 2 | Register selector: 0 base, 1 limit, 2 control, 3 global |
| cfg_idx | input | IDX_W (2) | Range entry index |
| cfg_wdata | input | ADDR_W (32) | Write data |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W (32) | Request address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Response present |
| rsp_local | output | 1 | Request is local |
| rsp_port | output | 1 | Selected scalability port |
| rsp_node | output | NODE_W (4) | Home node |
| rsp_kind | output | 2 | 0 snoop, 1 read, 2 write |
| mc_valid | output | 1 | Data access issued to the local memory controller |
| mc_write | output | 1 | Memory controller access is a write |

## Verification
The assertions check the following on every cycle: the one-cycle response timing, the request kind for local and for remote results, the port interleave against the live default-port register, and the forcing of local results in single-node mode. The bench scenarios cover the rest. These are the inclusive range bounds, lowest-index priority among overlapping entries, disabled entries, the default home node on a miss, and a request that coincides with a register write.

// File: rtl/mrr_pkg.sv
package mrr_pkg;

    typedef enum logic [1:0] {
        KIND_SNOOP = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        FLD_BASE   = 2'd0,
        FLD_LIMIT  = 2'd1,
        FLD_CTRL   = 2'd2,
        FLD_GLOBAL = 2'd3
    } cfg_field_e;

endpackage

// File: rtl/mrr_cfg_regs.sv
module mrr_cfg_regs #(
    parameter int ADDR_W     = 32,
    parameter int NODE_W     = 4,
    parameter int NUM_RANGES = 4,
    localparam int IDX_W     = $clog2(NUM_RANGES)
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                cfg_we,
    input  logic [1:0]                          cfg_field,
    input  logic [IDX_W-1:0]                    cfg_idx,
    input  logic [ADDR_W-1:0]                   cfg_wdata,
    output logic [NUM_RANGES-1:0]               rng_en,
    output logic [NUM_RANGES-1:0][NODE_W-1:0]   rng_node,
    output logic [NUM_RANGES-1:0][ADDR_W-1:0]   rng_base,
    output logic [NUM_RANGES-1:0][ADDR_W-1:0]   rng_limit,
    output logic                                dflt_port,
    output logic [NODE_W-1:0]                   dflt_node
);
    import mrr_pkg::*;

    typedef struct packed {
        logic [NUM_RANGES-1:0]             en;
        logic [NUM_RANGES-1:0][NODE_W-1:0] node;
        logic [NUM_RANGES-1:0][ADDR_W-1:0] base;
        logic [NUM_RANGES-1:0][ADDR_W-1:0] limit;
        logic                              dport;
        logic [NODE_W-1:0]                 dnode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            unique case (cfg_field_e'(cfg_field))
                FLD_BASE: begin
                    if (int'(cfg_idx) < NUM_RANGES)
                        cfg_d.base[cfg_idx] = cfg_wdata;
                end
                FLD_LIMIT: begin
                    if (int'(cfg_idx) < NUM_RANGES)
                        cfg_d.limit[cfg_idx] = cfg_wdata;
                end
                FLD_CTRL: begin
                    if (int'(cfg_idx) < NUM_RANGES) begin
                        cfg_d.en[cfg_idx]   = cfg_wdata[0];
                        cfg_d.node[cfg_idx] = cfg_wdata[NODE_W:1];
                    end
                end
                FLD_GLOBAL: begin
                    cfg_d.dport = cfg_wdata[0];
                    cfg_d.dnode = cfg_wdata[NODE_W:1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    assign rng_en    = cfg_q.en;
    assign rng_node  = cfg_q.node;
    assign rng_base  = cfg_q.base;
    assign rng_limit = cfg_q.limit;
    assign dflt_port = cfg_q.dport;
    assign dflt_node = cfg_q.dnode;

endmodule

// File: rtl/mrr_range_match.sv
module mrr_range_match #(
    parameter int ADDR_W     = 32,
    parameter int NODE_W     = 4,
    parameter int NUM_RANGES = 4
) (
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [NUM_RANGES-1:0]               rng_en,
    input  logic [NUM_RANGES-1:0][NODE_W-1:0]   rng_node,
    input  logic [NUM_RANGES-1:0][ADDR_W-1:0]   rng_base,
    input  logic [NUM_RANGES-1:0][ADDR_W-1:0]   rng_limit,
    output logic                                hit,
    output logic [NODE_W-1:0]                   hit_node
);
    logic [NUM_RANGES-1:0] hit_vec;

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_cmp
        assign hit_vec[g] = rng_en[g]
                          && (addr >= rng_base[g])
                          && (addr <= rng_limit[g]);
    end

    // Lowest index wins: scan from the top so lower entries overwrite.
    always_comb begin
        hit_node = '0;
        for (int i = NUM_RANGES - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_node = rng_node[i];
        end
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/mrr_port_sel.sv
module mrr_port_sel #(
    parameter int ADDR_W    = 32,
    parameter int LINE_BITS = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              dflt_port,
    output logic              port
);
    // Bit just above the line offset alternates around the default port.
    assign port = addr[LINE_BITS] ^ dflt_port;

endmodule

// File: rtl/mem_req_router.sv
module mem_req_router #(
    parameter int ADDR_W     = 32,
    parameter int NODE_W     = 4,
    parameter int NUM_RANGES = 4,
    parameter int LINE_BITS  = 6,
    localparam int IDX_W     = $clog2(NUM_RANGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              single_node,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_field,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic              rsp_local,
    output logic              rsp_port,
    output logic [NODE_W-1:0] rsp_node,
    output logic [1:0]        rsp_kind,
    output logic              mc_valid,
    output logic              mc_write
);
    import mrr_pkg::*;

    typedef struct packed {
        logic              valid;
        logic              is_local;
        logic              port;
        logic [NODE_W-1:0] node;
        req_kind_e         kind;
        logic              mc_valid;
        logic              mc_write;
    } rsp_t;

    logic [NUM_RANGES-1:0]             rng_en;
    logic [NUM_RANGES-1:0][NODE_W-1:0] rng_node;
    logic [NUM_RANGES-1:0][ADDR_W-1:0] rng_base;
    logic [NUM_RANGES-1:0][ADDR_W-1:0] rng_limit;
    logic                              dflt_port;
    logic [NODE_W-1:0]                 dflt_node;
    logic                              hit;
    logic [NODE_W-1:0]                 hit_node;
    logic                              port_sel;

    mrr_cfg_regs #(
        .ADDR_W(ADDR_W), .NODE_W(NODE_W), .NUM_RANGES(NUM_RANGES)
    ) u_cfg (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_field(cfg_field), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata),
        .rng_en(rng_en), .rng_node(rng_node),
        .rng_base(rng_base), .rng_limit(rng_limit),
        .dflt_port(dflt_port), .dflt_node(dflt_node)
    );

    mrr_range_match #(
        .ADDR_W(ADDR_W), .NODE_W(NODE_W), .NUM_RANGES(NUM_RANGES)
    ) u_match (
        .addr(req_addr),
        .rng_en(rng_en), .rng_node(rng_node),
        .rng_base(rng_base), .rng_limit(rng_limit),
        .hit(hit), .hit_node(hit_node)
    );

    mrr_port_sel #(
        .ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS)
    ) u_port (
        .addr(req_addr), .dflt_port(dflt_port), .port(port_sel)
    );

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid    = 1'b1;
            rsp_d.is_local = hit || single_node;
            rsp_d.port     = port_sel;
            rsp_d.node     = hit ? hit_node : dflt_node;
            if (rsp_d.is_local)
                rsp_d.kind = KIND_SNOOP;
            else
                rsp_d.kind = req_write ? KIND_WRITE : KIND_READ;
            rsp_d.mc_valid = rsp_d.is_local;
            rsp_d.mc_write = rsp_d.is_local && req_write;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_local = rsp_q.is_local;
    assign rsp_port  = rsp_q.port;
    assign rsp_node  = rsp_q.node;
    assign rsp_kind  = rsp_q.kind;
    assign mc_valid  = rsp_q.mc_valid;
    assign mc_write  = rsp_q.mc_write;

endmodule

// File: rtl/mrr_checker.sv
module mrr_checker #(
    parameter int ADDR_W    = 32,
    parameter int LINE_BITS = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              single_node,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_write,
    input logic              dflt_port,
    input logic              rsp_valid,
    input logic              rsp_local,
    input logic              rsp_port,
    input logic [1:0]        rsp_kind,
    input logic              mc_valid,
    input logic              mc_write
);
    assert_resp_timing_R1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == ($past(req_valid) && !$past(rst)));

    assert_local_snoop_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_local) |-> (rsp_kind == 2'd0 && mc_valid));

    assert_remote_rw_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_local) |->
            (rsp_kind == ($past(req_write) ? 2'd2 : 2'd1) && !mc_valid && !mc_write));

    assert_port_interleave_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_port == ($past(req_addr[LINE_BITS]) ^ $past(dflt_port))));

    assert_single_node_local_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(single_node)) |-> rsp_local);

endmodule

bind mem_req_router mrr_checker #(
    .ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS)
) u_chk (
    .clk(clk), .rst(rst), .single_node(single_node),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .dflt_port(dflt_port),
    .rsp_valid(rsp_valid), .rsp_local(rsp_local), .rsp_port(rsp_port),
    .rsp_kind(rsp_kind), .mc_valid(mc_valid), .mc_write(mc_write)
);

// File: tb/mem_req_router_tb.sv
module mem_req_router_tb;
    localparam int AW = 32;
    localparam int NW = 4;
    localparam int NR = 4;
    localparam int LB = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic single_node = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_field = '0;
    logic [1:0] cfg_idx = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic req_write = 1'b0;
    logic rsp_valid, rsp_local, rsp_port, mc_valid, mc_write;
    logic [NW-1:0] rsp_node;
    logic [1:0] rsp_kind;

    always #4 clk = ~clk;

    mem_req_router u_dut (.*);

    int total = 0;
    int bad = 0;

    logic [AW-1:0] m_base [NR];
    logic [AW-1:0] m_limit[NR];
    logic          m_en   [NR];
    logic [NW-1:0] m_node [NR];
    logic          m_dport = 1'b0;
    logic [NW-1:0] m_dnode = '0;

    // Expected response packed as {valid,local,port,node,kind,mc_valid,mc_write}
    function automatic logic [10:0] model(input logic [AW-1:0] a, input logic w,
                                          input logic sn);
        logic hit = 1'b0;
        logic [NW-1:0] nd = m_dnode;
        logic loc;
        logic [1:0] k;
        for (int i = 0; i < NR; i++) begin
            if (!hit && m_en[i] && a >= m_base[i] && a <= m_limit[i]) begin
                hit = 1'b1;
                nd  = m_node[i];
            end
        end
        loc = hit || sn;
        k = loc ? 2'd0 : (w ? 2'd2 : 2'd1);
        return {1'b1, loc, a[LB] ^ m_dport, nd, k, loc, loc & w};
    endfunction

    function automatic logic [10:0] observed();
        return {rsp_valid, rsp_local, rsp_port, rsp_node, rsp_kind, mc_valid, mc_write};
    endfunction

    task automatic check(input string req, input logic [10:0] exp);
        total++;
        if (observed() !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", req, observed(), exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] f, input logic [1:0] idx,
                             input logic [AW-1:0] d);
        cfg_we = 1'b1; cfg_field = f; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (f)
            2'd0: m_base[idx]  = d;
            2'd1: m_limit[idx] = d;
            2'd2: begin m_en[idx] = d[0]; m_node[idx] = d[NW:1]; end
            default: begin m_dport = d[0]; m_dnode = d[NW:1]; end
        endcase
    endtask

    task automatic set_range(input int idx, input logic [AW-1:0] b,
                             input logic [AW-1:0] l, input logic en,
                             input logic [NW-1:0] nd);
        cfg_write(2'd0, idx[1:0], b);
        cfg_write(2'd1, idx[1:0], l);
        cfg_write(2'd2, idx[1:0], {{(AW-NW-1){1'b0}}, nd, en});
    endtask

    task automatic request(input string req, input logic [AW-1:0] a, input logic w);
        logic [10:0] exp;
        exp = model(a, w, single_node);
        req_valid = 1'b1; req_addr = a; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [10:0] exp;
        void'($urandom(32'd4242));
        for (int i = 0; i < NR; i++) begin
            m_base[i] = '0; m_limit[i] = '0; m_en[i] = 1'b0; m_node[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 / R1: idle outputs zero after reset
        check("R10 reset outputs", 11'd0);
        // R10: reset state means every address misses, default node 0, port 0
        request("R10 reset routes remote", 32'h0000_1000, 1'b0);
        request("R4 miss read", 32'h0000_1040, 1'b0);

        // R9: global word
        cfg_write(2'd3, 2'd0, {{(AW-NW-1){1'b0}}, 4'd9, 1'b1});
        request("R7 port flip with default 1", 32'h0000_0000, 1'b1);
        request("R7 port bit set", 32'h0000_0040, 1'b1);

        // R2 inclusive bounds
        set_range(0, 32'h0001_0000, 32'h0001_FFFF, 1'b1, 4'd3);
        request("R2 lower bound", 32'h0001_0000, 1'b0);
        request("R2 upper bound write R5", 32'h0001_FFFF, 1'b1);
        request("R4 just above limit", 32'h0002_0000, 1'b1);
        request("R4 just below base", 32'h0000_FFFF, 1'b0);

        // R3 overlap: entry 2 covers entry 0 too, lower index wins
        set_range(2, 32'h0000_8000, 32'h0003_0000, 1'b1, 4'd7);
        request("R3 overlap lowest wins", 32'h0001_8000, 1'b0);
        request("R3 only entry 2", 32'h0002_8000, 1'b0);

        // R11 disabled entry ignored
        set_range(1, 32'h0010_0000, 32'h0010_FFFF, 1'b0, 4'd5);
        request("R11 disabled entry", 32'h0010_0040, 1'b1);

        // R8 single node
        single_node = 1'b1;
        request("R8 single node miss local", 32'h0050_0000, 1'b1);
        request("R8 single node hit", 32'h0001_0040, 1'b0);
        single_node = 1'b0;

        // R9 same-cycle write: request sees old settings
        exp = model(32'h0010_0000, 1'b0, 1'b0);
        cfg_we = 1'b1; cfg_field = 2'd2; cfg_idx = 2'd1;
        cfg_wdata = {{(AW-NW-1){1'b0}}, 4'd5, 1'b1};
        req_valid = 1'b1; req_addr = 32'h0010_0000; req_write = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check("R9 same-cycle write uses old", exp);
        m_en[1] = 1'b1; m_node[1] = 4'd5;
        request("R9 new setting applies", 32'h0010_0000, 1'b0);
        // R9: global write ignores cfg_idx
        cfg_write(2'd3, 2'd2, {{(AW-NW-1){1'b0}}, 4'd2, 1'b0});
        request("R9 global ignores index", 32'h0040_0040, 1'b0);

        // R1: idle cycle after request
        @(negedge clk);
        check("R1 idle zero", 11'd0);

        // Random mix around the programmed bounds
        for (int n = 0; n < 600; n++) begin
            logic [AW-1:0] a;
            int sel;
            if (n % 100 == 0) begin
                for (int r = 0; r < NR; r++) begin
                    logic [AW-1:0] b;
                    b = {12'd0, 20'($urandom)} & 32'hFFFF_F000;
                    set_range(r, b, b + ({20'd0, 12'($urandom)} << 4),
                              1'($urandom), 4'($urandom));
                end
                cfg_write(2'd3, 2'($urandom), {{(AW-NW-1){1'b0}}, 4'($urandom), 1'($urandom)});
            end
            sel = int'($urandom % 4);
            case (sel)
                0: a = m_base[$urandom % NR];
                1: a = m_limit[$urandom % NR];
                2: a = m_limit[$urandom % NR] + 32'd1;
                default: a = {12'd0, 20'($urandom)};
            endcase
            single_node = ($urandom % 8) == 0;
            request("R2 R3 R4 R6 R7 random", a, 1'($urandom));
            if ($urandom % 5 == 0) begin
                @(negedge clk);
                check("R1 random idle", 11'd0);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule